// File: doc/BRIEF.md
# MII Management Frame Register Decoder

This block sits behind a host register interface and turns a 32-bit management frame word into an access on an internal 32-entry, 16-bit register file that stands in for a built-in PHY. Software writes the frame word, then polls the stored copy until the completion flag (bit 16) reads as 1. For a read, the low 16 bits of that stored copy then hold the register content.

Only frames that carry a start code of 01 and name PHY address 1 touch the register file. Every other frame is still marked complete, so the software polling loop always ends. Writes to the PHY control word have side effects that clear themselves: a soft reset turns autonegotiation on, and an autonegotiation restart completes at once and reports the link state. A link input models the cable. Any change on it updates the link bits and floods the 16-bit management interrupt status. A separate configuration register holds two transceiver-present bits that software cannot change.

Top module: `mgmt_frame_top`

## Requirements
- R1: A frame write stores the written word with bit 16 forced to 0 on the next clock edge. One edge later bit 16 becomes 1, and bits 31:17 remain as written. A new frame write made while one is still pending replaces the pending frame.
- R2: A frame whose start field (bits 31:30) is not 01, or whose PHY address (bits 27:23) is not 1, accesses no register. It completes with bits 15:0 unchanged and bit 16 set.
- R3: Opcode 01 (bits 29:28) stores bits 15:0 into the register selected by bits 22:18. A later read returns that value.
- R4: Opcode 10 replaces bits 15:0 of the stored frame with the register content. This happens on the same edge that sets bit 16, and all other bits are kept.
- R5: Opcodes 00 and 11 access nothing. They complete with the data field unchanged and bit 16 set.
- R6: Writing register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R7: Writing register 0 with bit 9 set stores bit 9 cleared and sets bit 5 of register 1. If the link is up, it also sets bit 2 of register 1 and bit 8 of register 5.
- R8: Registers 2 and 3 always read as the identifier parameters. Writes to them have no effect.
- R9: The configuration register resets to 0x00000100. Writes keep bits 9:8 and load every other bit.
- R10: After reset, the frame word and interrupt status are 0. Register 1 reads 0x4028, or 0x402C with the link up. Register 4 reads 0x0100. Register 5 reads 0x0100 with the link up and 0 otherwise. Register 0 and registers 6 to 31 read 0.
- R11: A change on the link input copies the new link state into bit 2 of register 1 and bit 8 of register 5, and sets the interrupt status to 0xFFFF, all on the next edge.
- R12: A clear request sets the interrupt status to 0. A link change on the same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_wr | input | 1 | Frame word write strobe |
| frame_wdata | input | 32 | Frame word to decode |
| frame_q | output | 32 | Stored frame word with completion flag and read data |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_q | output | 32 | Configuration register contents |
| link_up | input | 1 | Link state of the modelled cable |
| stat_clr | input | 1 | Clears the interrupt status |
| mgmt_stat | output | 16 | Management interrupt status |

## Verification
The assertions check the frame handshake on every cycle. On the edge after a frame write, the completion flag must be clear and the upper bits must match the write. One edge later the flag must be set, and it must then stay set until the next write. The assertions also check that the read-only configuration bits hold, that a link change floods the status, and that a clear empties it. The bench's scenarios are the only place where the register-file contents can be shown. These cover the read-back of every register, the swept rejection of wrong PHY addresses and start codes, the self-clearing control bits, and the identifier registers that ignore writes.

// File: rtl/mgmt_pkg.sv
// Shared field positions, codes and register indices for the management block.
// Assumes the frame word is 32 bits and PHY registers are 16 bits.
package mgmt_pkg;
    localparam int FRM_W = 32;
    localparam int DONE_BIT = 16;

    // Frame word layout, most significant field first.
    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [1:0]  ta;
        logic [15:0] data;
    } mgmt_frame_t;

    localparam logic [1:0] ST_VALID = 2'b01;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;

    // PHY register indices.
    localparam int REG_CTL = 0;
    localparam int REG_STS = 1;
    localparam int REG_IDH = 2;
    localparam int REG_IDL = 3;
    localparam int REG_ADV = 4;
    localparam int REG_LPA = 5;

    // Bit positions inside those registers.
    localparam int CTL_RST   = 15;
    localparam int CTL_ANEN  = 12;
    localparam int CTL_ANRST = 9;
    localparam int STS_100FD = 14;
    localparam int STS_ANCMP = 5;
    localparam int STS_ANABL = 3;
    localparam int STS_LINK  = 2;
    localparam int ABL_100FD = 8;
endpackage

// File: rtl/mgmt_frame_decode.sv
// Decodes the frame header into a register write or read request.
// Assumes only one PHY address is served; all other frames are rejected.
module mgmt_frame_decode #(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic [1:0] st,
    input  logic [1:0] op,
    input  logic [4:0] phy,
    output logic       do_wr,
    output logic       do_rd
);
    import mgmt_pkg::*;

    logic hit;

    // Accept only a valid start code addressed to this PHY, then split on opcode.
    always_comb begin
        hit   = (st == ST_VALID) && (phy == PHY_ADDR);
        do_wr = hit && (op == OP_WR);
        do_rd = hit && (op == OP_RD);
    end
endmodule

// File: rtl/mgmt_phy_regs.sv
// Register file of the modelled PHY, with control-word side effects and link tracking.
// Assumes NREG is a power of two of at least 6; the identifier words are constants.
module mgmt_phy_regs #(
    parameter int          NREG  = 32,
    parameter int          W     = 16,
    parameter logic [15:0] ID_HI = 16'h1A2B,
    parameter logic [15:0] ID_LO = 16'h3C4D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] addr,
    input  logic [W-1:0]            wdata,
    input  logic                    link_up,
    output logic [W-1:0]            rd_data,
    output logic                    link_evt
);
    import mgmt_pkg::*;

    localparam int AW = $clog2(NREG);
    localparam logic [AW-1:0] A_CTL = AW'(REG_CTL);
    localparam logic [AW-1:0] A_IDH = AW'(REG_IDH);
    localparam logic [AW-1:0] A_IDL = AW'(REG_IDL);

    logic [W-1:0] regs  [NREG];
    logic [W-1:0] nxt   [NREG];
    logic [W-1:0] words [NREG];
    logic [W-1:0] ctl_v;
    logic         link_q;

    // Reset contents of one register, given the link state at reset.
    function automatic logic [W-1:0] rst_word(input int idx, input logic lk);
        logic [W-1:0] v;
        v = '0;
        if (idx == REG_STS) begin
            v[STS_100FD] = 1'b1;
            v[STS_ANCMP] = 1'b1;
            v[STS_ANABL] = 1'b1;
            v[STS_LINK]  = lk;
        end
        if (idx == REG_ADV) v[ABL_100FD] = 1'b1;
        if (idx == REG_LPA) v[ABL_100FD] = lk;
        return v;
    endfunction

    assign link_evt = (link_up != link_q);

    // Next-state of the file: host write with control side effects, then link override.
    always_comb begin
        nxt   = regs;
        ctl_v = wdata;
        if (wr_en) begin
            if (addr == A_CTL) begin
                if (ctl_v[CTL_RST]) begin
                    ctl_v[CTL_RST]  = 1'b0;
                    ctl_v[CTL_ANEN] = 1'b1;
                end
                if (ctl_v[CTL_ANRST]) begin
                    ctl_v[CTL_ANRST]          = 1'b0;
                    nxt[REG_STS][STS_ANCMP]   = 1'b1;
                    if (link_up) begin
                        nxt[REG_STS][STS_LINK]  = 1'b1;
                        nxt[REG_LPA][ABL_100FD] = 1'b1;
                    end
                end
                nxt[REG_CTL] = ctl_v;
            end else if (addr != A_IDH && addr != A_IDL) begin
                nxt[addr] = wdata;
            end
        end
        if (link_evt) begin
            nxt[REG_STS][STS_LINK]  = link_up;
            nxt[REG_LPA][ABL_100FD] = link_up;
        end
    end

    // State update: reset values or the computed next state; link sampled each cycle.
    always_ff @(posedge clk) begin
        link_q <= link_up;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= rst_word(i, link_up);
        end else begin
            regs <= nxt;
        end
    end

    // Read view: identifier slots come from parameters, the rest from storage.
    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (g == REG_IDH) begin : g_idh
            assign words[g] = ID_HI;
        end else if (g == REG_IDL) begin : g_idl
            assign words[g] = ID_LO;
        end else begin : g_mem
            assign words[g] = regs[g];
        end
    end

    assign rd_data = words[addr];
endmodule

// File: rtl/mgmt_cfg_reg.sv
// Host configuration register whose masked bits ignore writes.
// Assumes the read-only bits only ever hold their reset value.
module mgmt_cfg_reg #(
    parameter int          W       = 32,
    parameter logic [31:0] RO_MASK = 32'h0000_0300,
    parameter logic [31:0] RST_VAL = 32'h0000_0100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MASK = RO_MASK[W-1:0];

    // Load writable bits, keep protected bits.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL[W-1:0];
        else if (wr) q <= (wdata & ~MASK) | (q & MASK);
    end
endmodule

// File: rtl/mgmt_frame_top.sv
// Management frame register: latches a frame, performs the access one cycle later
// and raises the completion flag. Assumes the host polls frame_q for bit 16.
module mgmt_frame_top #(
    parameter int          NREG     = 32,
    parameter logic [4:0]  PHY_ADDR = 5'd1,
    parameter logic [15:0] ID_HI    = 16'h1A2B,
    parameter logic [15:0] ID_LO    = 16'h3C4D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_wr,
    input  logic [31:0] frame_wdata,
    output logic [31:0] frame_q,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_q,
    input  logic        link_up,
    input  logic        stat_clr,
    output logic [15:0] mgmt_stat
);
    import mgmt_pkg::*;

    localparam int AW = $clog2(NREG);

    mgmt_frame_t frm;
    logic        pend;
    logic        do_wr;
    logic        do_rd;
    logic        link_evt;
    logic [15:0] rd_data;

    assign frm = mgmt_frame_t'(frame_q);

    mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
        .st    (frm.st),
        .op    (frm.op),
        .phy   (frm.phy),
        .do_wr (do_wr),
        .do_rd (do_rd)
    );

    mgmt_phy_regs #(.NREG(NREG), .W(16), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pend && !frame_wr && do_wr),
        .addr     (frm.ra[AW-1:0]),
        .wdata    (frm.data),
        .link_up  (link_up),
        .rd_data  (rd_data),
        .link_evt (link_evt)
    );

    mgmt_cfg_reg #(.W(32)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    // Frame word: capture with the flag cleared, then complete one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            pend    <= 1'b0;
        end else if (frame_wr) begin
            frame_q           <= frame_wdata;
            frame_q[DONE_BIT] <= 1'b0;
            pend              <= 1'b1;
        end else if (pend) begin
            pend              <= 1'b0;
            frame_q[DONE_BIT] <= 1'b1;
            if (do_rd) frame_q[15:0] <= rd_data;
        end
    end

    // Interrupt status: flooded on a link change, otherwise cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        mgmt_stat <= '0;
        else if (link_evt) mgmt_stat <= 16'hFFFF;
        else if (stat_clr) mgmt_stat <= '0;
    end
endmodule

// File: rtl/mgmt_frame_chk.sv
// Cycle checks on the management block ports, attached by bind.
// Assumes the synchronous active-low reset is held for at least one edge.
module mgmt_frame_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_wr,
    input logic [31:0] frame_wdata,
    input logic [31:0] frame_q,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_q,
    input logic        link_up,
    input logic        stat_clr,
    input logic [15:0] mgmt_stat
);
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> (!frame_q[16] && frame_q[31:17] == $past(frame_wdata[31:17])));

    p_complete_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr ##1 !frame_wr |=> frame_q[16]);

    p_done_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q[16] && !frame_wr) |=> frame_q[16]);

    p_ro_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q[9:8] == $past(cfg_q[9:8])));

    p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q[7:0] == $past(cfg_wdata[7:0])));

    p_link_flood_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != $past(link_up)) |=> (mgmt_stat == 16'hFFFF));

    p_stat_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && link_up == $past(link_up)) |=> (mgmt_stat == 16'h0000));
endmodule

bind mgmt_frame_top mgmt_frame_chk u_chk (.*);

// File: tb/mgmt_frame_top_tb.sv
module mgmt_frame_top_tb;
    localparam logic [15:0] IDH = 16'h1A2B;
    localparam logic [15:0] IDL = 16'h3C4D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic [31:0] frame_q;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_q;
    logic        link_up = 1'b1;
    logic        stat_clr = 1'b0;
    logic [15:0] mgmt_stat;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mgmt_frame_top u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mkf(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] ra,
                                        input logic [15:0] d);
        return {st, op, phy, ra, 2'b00, d};
    endfunction

    // Issues a frame, checks the capture (R1) and completion, returns the final word.
    task automatic frame(input logic [31:0] w, output logic [31:0] res);
        @(negedge clk);
        frame_wdata = w;
        frame_wr = 1'b1;
        @(negedge clk);
        frame_wr = 1'b0;
        chk("R1 capture", frame_q, w & ~32'h0001_0000);
        @(negedge clk);
        res = frame_q;
        chk("R1 done", {31'd0, res[16]}, 32'd1);
    endtask

    task automatic phy_wr(input logic [4:0] ra, input logic [15:0] d);
        logic [31:0] r;
        frame(mkf(2'b01, 2'b01, 5'd1, ra, d), r);
    endtask

    task automatic phy_rd(input logic [4:0] ra, output logic [15:0] d);
        logic [31:0] r;
        logic [31:0] w;
        w = mkf(2'b01, 2'b10, 5'd1, ra, 16'hA5A5);
        frame(w, r);
        chk("R4 upper bits kept", {r[31:17], 17'd0}, {w[31:17], 17'd0});
        d = r[15:0];
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        @(negedge clk);
        chk("R11 status flood", {16'd0, mgmt_stat}, 32'h0000_FFFF);
    endtask

    initial begin
        logic [15:0] d;
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R9 reset value
        chk("R10 frame reset", frame_q, 32'd0);
        chk("R10 status reset", {16'd0, mgmt_stat}, 32'd0);
        chk("R9 cfg reset", cfg_q, 32'h0000_0100);
        phy_rd(5'd0, d);  chk("R10 reg0", {16'd0, d}, 32'h0000);
        phy_rd(5'd1, d);  chk("R10 reg1 link up", {16'd0, d}, 32'h402C);
        phy_rd(5'd4, d);  chk("R10 reg4", {16'd0, d}, 32'h0100);
        phy_rd(5'd5, d);  chk("R10 reg5", {16'd0, d}, 32'h0100);
        for (int i = 6; i < 32; i++) begin
            phy_rd(5'(i), d);
            chk("R10 upper regs zero", {16'd0, d}, 32'd0);
        end
        // R8 identifier registers fixed
        phy_rd(5'd2, d);  chk("R8 id hi", {16'd0, d}, {16'd0, IDH});
        phy_rd(5'd3, d);  chk("R8 id lo", {16'd0, d}, {16'd0, IDL});
        phy_wr(5'd2, 16'h0000);
        phy_wr(5'd3, 16'hFFFF);
        phy_rd(5'd2, d);  chk("R8 id hi after write", {16'd0, d}, {16'd0, IDH});
        phy_rd(5'd3, d);  chk("R8 id lo after write", {16'd0, d}, {16'd0, IDL});
        // R3 write sweep with computed patterns, then read back
        for (int i = 6; i < 32; i++) phy_wr(5'(i), 16'(i * 16'h0101) ^ 16'h5A5A);
        phy_wr(5'd4, 16'h01E1);
        for (int i = 6; i < 32; i++) begin
            phy_rd(5'(i), d);
            chk("R3 readback", {16'd0, d}, {16'd0, 16'(i * 16'h0101) ^ 16'h5A5A});
        end
        phy_rd(5'd4, d);  chk("R3 reg4 readback", {16'd0, d}, 32'h01E1);
        // R2 rejected PHY addresses
        for (int p = 0; p < 32; p++) begin
            if (p != 1) begin
                frame(mkf(2'b01, 2'b01, 5'(p), 5'd10, 16'hDEAD), r);
                chk("R2 wrong phy", r, mkf(2'b01, 2'b01, 5'(p), 5'd10, 16'hDEAD) | 32'h0001_0000);
                frame(mkf(2'b01, 2'b10, 5'(p), 5'd10, 16'h1234), r);
                chk("R2 wrong phy read", r, mkf(2'b01, 2'b10, 5'(p), 5'd10, 16'h1234) | 32'h0001_0000);
            end
        end
        // R2 rejected start codes
        for (int s = 0; s < 4; s++) begin
            if (s != 1) begin
                frame(mkf(2'(s), 2'b01, 5'd1, 5'd10, 16'hBEEF), r);
                chk("R2 bad start", r, mkf(2'(s), 2'b01, 5'd1, 5'd10, 16'hBEEF) | 32'h0001_0000);
            end
        end
        phy_rd(5'd10, d);
        chk("R2 reg untouched", {16'd0, d}, {16'd0, 16'(10 * 16'h0101) ^ 16'h5A5A});
        // R5 null opcodes
        frame(mkf(2'b01, 2'b00, 5'd1, 5'd11, 16'h7777), r);
        chk("R5 op00", r, mkf(2'b01, 2'b00, 5'd1, 5'd11, 16'h7777) | 32'h0001_0000);
        frame(mkf(2'b01, 2'b11, 5'd1, 5'd11, 16'h8888), r);
        chk("R5 op11", r, mkf(2'b01, 2'b11, 5'd1, 5'd11, 16'h8888) | 32'h0001_0000);
        phy_rd(5'd11, d);
        chk("R5 reg untouched", {16'd0, d}, {16'd0, 16'(11 * 16'h0101) ^ 16'h5A5A});
        // R1 back-to-back: second frame supersedes the first
        @(negedge clk); frame_wdata = mkf(2'b01, 2'b01, 5'd1, 5'd12, 16'h1111); frame_wr = 1'b1;
        @(negedge clk); frame_wdata = mkf(2'b01, 2'b01, 5'd1, 5'd13, 16'h2222);
        @(negedge clk); frame_wr = 1'b0;
        @(negedge clk);
        chk("R1 superseded done", frame_q, mkf(2'b01, 2'b01, 5'd1, 5'd13, 16'h2222) | 32'h0001_0000);
        phy_rd(5'd12, d); chk("R1 superseded dropped", {16'd0, d}, {16'd0, 16'(12 * 16'h0101) ^ 16'h5A5A});
        phy_rd(5'd13, d); chk("R1 second applied", {16'd0, d}, 32'h2222);
        // R6 soft reset bit
        phy_wr(5'd0, 16'h8000);
        phy_rd(5'd0, d);  chk("R6 reset bit", {16'd0, d}, 32'h1000);
        phy_wr(5'd0, 16'h8123);
        phy_rd(5'd0, d);  chk("R6 reset with others", {16'd0, d}, 32'h1123);
        // R7 restart with link up
        phy_wr(5'd1, 16'h0000);
        phy_wr(5'd5, 16'h0000);
        phy_wr(5'd0, 16'h0200);
        phy_rd(5'd0, d);  chk("R7 restart clears", {16'd0, d}, 32'h0000);
        phy_rd(5'd1, d);  chk("R7 status link up", {16'd0, d}, 32'h0024);
        phy_rd(5'd5, d);  chk("R7 partner link up", {16'd0, d}, 32'h0100);
        // R11 link down then R7 with link down
        phy_wr(5'd1, 16'hFFFF);
        phy_wr(5'd5, 16'hFFFF);
        set_link(1'b0);
        phy_rd(5'd1, d);  chk("R11 link down status", {16'd0, d}, 32'hFFFB);
        phy_rd(5'd5, d);  chk("R11 link down partner", {16'd0, d}, 32'hFEFF);
        phy_wr(5'd1, 16'h0000);
        phy_wr(5'd5, 16'h0000);
        phy_wr(5'd0, 16'h8200);
        phy_rd(5'd0, d);  chk("R7 combined bits", {16'd0, d}, 32'h1000);
        phy_rd(5'd1, d);  chk("R7 status link down", {16'd0, d}, 32'h0020);
        phy_rd(5'd5, d);  chk("R7 partner link down", {16'd0, d}, 32'h0000);
        // R12 clear, then R11 link up
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
        chk("R12 clear", {16'd0, mgmt_stat}, 32'd0);
        set_link(1'b1);
        phy_rd(5'd1, d);  chk("R11 link up status", {16'd0, d}, 32'h0024);
        phy_rd(5'd5, d);  chk("R11 link up partner", {16'd0, d}, 32'h0100);
        // R12 clear loses to a simultaneous link change
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); chk("R12 clear again", {16'd0, mgmt_stat}, 32'd0);
        link_up = 1'b0;
        @(negedge clk); stat_clr = 1'b0;
        chk("R12 link wins", {16'd0, mgmt_stat}, 32'h0000_FFFF);
        // R9 configuration masks
        @(negedge clk); cfg_wdata = 32'hFFFF_FFFF; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R9 write ones", cfg_q, 32'hFFFF_FDFF);
        @(negedge clk); cfg_wdata = 32'h0000_0000; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R9 write zeros", cfg_q, 32'h0000_0100);
        // R10 reset with link down
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        phy_rd(5'd1, d);  chk("R10 reg1 link down", {16'd0, d}, 32'h4028);
        phy_rd(5'd5, d);  chk("R10 reg5 link down", {16'd0, d}, 32'h0000);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule